// File: doc/BRIEF.md
# Two-Stage I2C Clock Rate Divider

This block turns the system clock into the timing reference for an I2C master's bit engine. Two programmable prescalers are stacked in series. The first divides the input clock by a 2-bit factor plus one. The second divides the first stage's output by a 6-bit factor plus one. Each output pulse of the second stage moves a 22-step phase sequencer forward by one step, and one full pass of the sequencer is one SCL period. The SCL period is therefore 22 × (A+1) × (B+1) input clocks.

The sequencer produces two outputs. The first is a free-running SCL reference that is low for steps 0 to 10 and high for steps 11 to 21. The second is a one-cycle quarter tick at the start of steps 0, 5, 11 and 16, which the bit engine uses to place its data changes and samples. Software chooses the divisor pair for the wanted bus rate; this block only applies it. The divisor fields are captured into a shadow copy only while the block is disabled or at the end of an SCL period. A change made during a running period therefore never produces a shortened low or high phase.

Top module: `scl_rate_divider`

## Requirements
- R1: While `enable` is low, `scl_ref` is 1, `quarter_tick` is 0 and all counters are held at zero, whatever the divisor inputs do.
- R2: Each sequencer step lasts (A+1)×(B+1) clocks, so consecutive rising edges of `scl_ref` are 22×(A+1)×(B+1) clocks apart.
- R3: Counting clocks c from the first enabled cycle, with N=(A+1)×(B+1) and p=(c mod 22N), `scl_ref` is 0 when p<11N and 1 otherwise.
- R4: `quarter_tick` is 1 for exactly one clock at the first clock of steps 0, 5, 11 and 16 of every period, and 0 at all other times.
- R5: `div_a` is a 2-bit factor giving divide ratios 1 to 4, and `div_b` is a 6-bit factor giving ratios 1 to 64. Both extremes work: A=0,B=0 gives a 22-clock period and A=3,B=63 gives a 5632-clock period (combined prescale 256).
- R6: A divisor change made while enabled has no effect until the running period ends. The next period then starts at step 0 with the new divisors.
- R7: In the first clock that `enable` is high, the sequencer is at step 0: `scl_ref` is 0 and `quarter_tick` is 1. After `enable` drops and rises again, the sequence restarts from step 0.
- R8: After reset, with `enable` low, `scl_ref` is 1 and `quarter_tick` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the dividers; low clears and holds them |
| div_a | input | 2 | First-stage divisor, ratio div_a+1 |
| div_b | input | 6 | Second-stage divisor, ratio div_b+1 |
| quarter_tick | output | 1 | One-clock strobe at steps 0, 5, 11, 16 |
| scl_ref | output | 1 | SCL reference, low for first half of each period |

## Verification
The assertions assume that `enable` and the divisor inputs change only between clock edges. They also assume that the divisor inputs may change at any time, including in the middle of a period, and they check that the shadow copy ignores such changes. The stimulus drives every input on the falling edge. It loads divisors while the block is disabled, with one deliberate change in the middle of a period. It also drops `enable` partway through a period, so the clear path and the restart path are both exercised.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  localparam int unsigned PHASE_STEPS = 22;
  localparam int unsigned HALF_STEP   = PHASE_STEPS / 2;
  localparam int unsigned Q1_STEP     = 5;
  localparam int unsigned Q3_STEP     = HALF_STEP + Q1_STEP;

  // Input clocks per SCL period for a divisor pair.
  function automatic int unsigned period_clocks(input int unsigned a, input int unsigned b);
    return PHASE_STEPS * (a + 1) * (b + 1);
  endfunction

  // Steps at which the bit engine is given a strobe.
  function automatic logic is_strobe_step(input int unsigned step);
    return (step == 0) || (step == Q1_STEP) || (step == HALF_STEP) || (step == Q3_STEP);
  endfunction

  // Steps during which SCL is released high.
  function automatic logic is_high_step(input int unsigned step);
    return step >= HALF_STEP;
  endfunction
endpackage

// File: rtl/div_stage.sv
module div_stage #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         adv,
  input  logic [W-1:0] limit,
  output logic         wrap
);
  logic [W-1:0] cnt;

  assign wrap = adv && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt <= '0;
    end else if (adv) begin
      cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq #(
  parameter int unsigned STEPS = 22,
  localparam int unsigned PW   = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          adv,
  output logic [PW-1:0] phase,
  output logic          last_step,
  output logic          step_first
);
  assign last_step = (phase == PW'(STEPS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      phase      <= '0;
      step_first <= 1'b1;
    end else if (adv) begin
      phase      <= last_step ? '0 : phase + 1'b1;
      step_first <= 1'b1;
    end else begin
      step_first <= 1'b0;
    end
  end
endmodule

// File: rtl/divisor_shadow.sv
module divisor_shadow #(
  parameter int unsigned AW = 2,
  parameter int unsigned BW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] div_a,
  input  logic [BW-1:0] div_b,
  output logic [AW-1:0] act_a,
  output logic [BW-1:0] act_b
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_a <= '0;
      act_b <= '0;
    end else if (load) begin
      act_a <= div_a;
      act_b <= div_b;
    end
  end
endmodule

// File: rtl/scl_rate_divider.sv
module scl_rate_divider
  import scl_div_pkg::*;
#(
  parameter int unsigned AW = 2,
  parameter int unsigned BW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [AW-1:0] div_a,
  input  logic [BW-1:0] div_b,
  output logic          quarter_tick,
  output logic          scl_ref
);
  localparam int unsigned PW = $clog2(PHASE_STEPS);

  logic [AW-1:0] act_a;
  logic [BW-1:0] act_b;
  logic          tick_a;
  logic          step_tick;
  logic [PW-1:0] phase;
  logic          last_step;
  logic          step_first;
  logic          period_end;
  logic          shadow_load;
  logic          hold_clear;

  assign hold_clear  = !enable;
  assign period_end  = step_tick && last_step;
  assign shadow_load = hold_clear || period_end;

  divisor_shadow #(.AW(AW), .BW(BW)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(shadow_load),
    .div_a(div_a), .div_b(div_b), .act_a(act_a), .act_b(act_b)
  );

  div_stage #(.W(AW)) u_stage_a (
    .clk(clk), .rst_n(rst_n), .clear(hold_clear),
    .adv(enable), .limit(act_a), .wrap(tick_a)
  );

  div_stage #(.W(BW)) u_stage_b (
    .clk(clk), .rst_n(rst_n), .clear(hold_clear),
    .adv(tick_a), .limit(act_b), .wrap(step_tick)
  );

  scl_phase_seq #(.STEPS(PHASE_STEPS)) u_seq (
    .clk(clk), .rst_n(rst_n), .clear(hold_clear), .adv(step_tick),
    .phase(phase), .last_step(last_step), .step_first(step_first)
  );

  assign quarter_tick = enable && step_first && is_strobe_step(int'(phase));
  assign scl_ref      = hold_clear || is_high_step(int'(phase));
endmodule

// File: rtl/scl_rate_checker.sv
module scl_rate_checker #(
  parameter int unsigned AW = 2,
  parameter int unsigned BW = 6,
  parameter int unsigned PW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          quarter_tick,
  input logic          scl_ref,
  input logic          step_tick,
  input logic          period_end,
  input logic [PW-1:0] phase,
  input logic [AW-1:0] act_a,
  input logic [BW-1:0] act_b
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (scl_ref && !quarter_tick));

  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (phase == '0));

  p_step_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !step_tick) |=> (!enable || $stable(phase)));

  p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase < PW'(22));

  p_scl_rise_mid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && $rose(scl_ref)) |-> (phase == PW'(11)));

  p_tick_steps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    quarter_tick |-> (phase == PW'(0) || phase == PW'(5) || phase == PW'(11) || phase == PW'(16)));

  p_tick_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (quarter_tick && !step_tick) |=> !quarter_tick);

  p_shadow_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !period_end) |=> ($stable(act_a) && $stable(act_b)));

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && period_end) |=> (!enable || phase == '0));
endmodule

bind scl_rate_divider scl_rate_checker #(.AW(AW), .BW(BW), .PW(PW)) u_chk (.*);

// File: tb/tb_scl_rate_divider.sv
module tb_scl_rate_divider;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int NVEC       = 6;
  // {div_a, div_b, expected SCL period in clocks}
  localparam logic [23:0] VEC [NVEC] = '{
    {2'd0, 6'd0,  16'd22},
    {2'd3, 6'd63, 16'd5632},
    {2'd1, 6'd2,  16'd132},
    {2'd2, 6'd5,  16'd396},
    {2'd0, 6'd63, 16'd1408},
    {2'd3, 6'd0,  16'd88}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] div_a = '0;
  logic [5:0] div_b = '0;
  logic       quarter_tick;
  logic       scl_ref;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int bad_scl, bad_tick, n_tick, rise1, rise2;
  logic prev_scl;

  scl_rate_divider dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_a(div_a), .div_b(div_b),
    .quarter_tick(quarter_tick), .scl_ref(scl_ref)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog: cycles %0d expected below %0d", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Sample count cycles from the current sample point; c is taken relative
  // to the start of a schedule with step length n. Leaves the bench at the
  // next sample point.
  task automatic run_seg(input int n, input int count);
    for (int c = 0; c < count; c++) begin
      int p;
      int step;
      logic exp_scl;
      logic exp_tick;
      p        = c % (22 * n);
      step     = p / n;
      exp_scl  = (p >= 11 * n);
      exp_tick = (p % n == 0) && (step == 0 || step == 5 || step == 11 || step == 16);
      if (scl_ref !== exp_scl) bad_scl++;
      if (quarter_tick !== exp_tick) bad_tick++;
      if (quarter_tick === 1'b1) n_tick++;
      if (scl_ref === 1'b1 && prev_scl === 1'b0) begin
        if (rise1 < 0) rise1 = cyc; else if (rise2 < 0) rise2 = cyc;
      end
      prev_scl = scl_ref;
      @(negedge clk); #1;
    end
  endtask

  task automatic clear_stats();
    bad_scl = 0; bad_tick = 0; n_tick = 0; rise1 = -1; rise2 = -1; prev_scl = 1'b0;
  endtask

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    #1;
    chk(scl_ref === 1'b1, "R8 scl_ref in reset", int'(scl_ref), 1);
    chk(quarter_tick === 1'b0, "R8 quarter_tick in reset", int'(quarter_tick), 0);
    @(negedge clk); rst_n = 1'b1; #1;
    chk(scl_ref === 1'b1 && quarter_tick === 1'b0, "R8 after reset release",
        int'({scl_ref, quarter_tick}), 2);

    // R1: disabled with divisors moving
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk); div_a = 2'(i); div_b = 6'(i * 7); #1;
        if (scl_ref !== 1'b1 || quarter_tick !== 1'b0) bad++;
      end
      chk(bad == 0, "R1 idle outputs while disabled", bad, 0);
    end

    // Table walk: R2, R3, R4, R5, R7
    for (int v = 0; v < NVEC; v++) begin
      int a;
      int b;
      int n;
      int per;
      a   = int'(VEC[v][23:22]);
      b   = int'(VEC[v][21:16]);
      per = int'(VEC[v][15:0]);
      n   = (a + 1) * (b + 1);
      @(negedge clk); enable = 1'b0; div_a = 2'(a); div_b = 6'(b);
      repeat (2) @(negedge clk);
      enable = 1'b1; #1;
      chk(scl_ref === 1'b0 && quarter_tick === 1'b1, "R7 first enabled cycle",
          int'({scl_ref, quarter_tick}), 1);
      clear_stats();
      run_seg(n, 2 * per + 1);
      chk(bad_scl == 0, "R3 scl_ref schedule", bad_scl, 0);
      chk(bad_tick == 0 && n_tick == 9, "R4 quarter_tick count", n_tick, 9);
      chk(rise2 - rise1 == per, "R2 SCL period", rise2 - rise1, per);
      if (v < 2) chk(rise2 - rise1 == per, "R5 extreme divisor period", rise2 - rise1, per);
    end

    // R6: change divisors in the middle of a period (A=1,B=1 -> A=0,B=2)
    @(negedge clk); enable = 1'b0; div_a = 2'd1; div_b = 6'd1;
    repeat (2) @(negedge clk);
    enable = 1'b1; #1;
    clear_stats();
    run_seg(4, 30);
    div_a = 2'd0; div_b = 6'd2;
    begin
      int p;
      for (int c = 30; c < 88; c++) begin
        p = c / 4;
        if (scl_ref !== (p >= 11)) bad_scl++;
        if (quarter_tick !== ((c % 4 == 0) && (p == 0 || p == 5 || p == 11 || p == 16))) bad_tick++;
        @(negedge clk); #1;
      end
    end
    run_seg(3, 66);
    chk(bad_scl == 0, "R6 scl_ref across divisor change", bad_scl, 0);
    chk(bad_tick == 0, "R6 quarter_tick across divisor change", bad_tick, 0);

    // R1/R7: drop enable mid-period, then restart at step 0
    div_a = 2'd1; div_b = 6'd3;
    run_seg(3, 40);
    enable = 1'b0; #1;
    chk(scl_ref === 1'b1 && quarter_tick === 1'b0, "R1 disable mid-period",
        int'({scl_ref, quarter_tick}), 2);
    repeat (5) @(negedge clk);
    enable = 1'b1; #1;
    clear_stats();
    run_seg(8, 176);
    chk(bad_scl == 0 && bad_tick == 0, "R7 restart from step 0", bad_scl + bad_tick, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule